// File: doc/BRIEF.md
# Two-Slot Edge Input Capture

This block watches an external pin and, on the edges selected by a 2-bit edge mode, copies a free-running counter value into one of two capture slots. The first qualifying edge after arming fills slot 1. The second fills slot 2. After that, edges are ignored until the block is rearmed. A capture event strobe fires after the first capture or after the second capture, as a select bit chooses. The strobe is meant to feed an interrupt status register outside this block.

The pin passes through a two-flop synchronizer before edge detection. The stored value is the counter value in the cycle the synchronized edge is seen. Captures happen only while the pin is configured as an input.

The block is rearmed in two ways. One is a one-cycle rearm strobe, driven when software clears the capture interrupt. The other is a change of the edge mode from disabled to any enabled mode. Rearming resets the slot count only; the slot contents are kept.

Top module: `edge_capture_unit`

## Requirements
- R1: The edge mode encoding is 0 = disabled, 1 = rising (low to high), 2 = falling (high to low), 3 = either edge. In mode 0 no capture takes place.
- R2: While `pin_is_input_i` is 0, no edge is captured and both slots hold their values.
- R3: After arming, the first qualifying edge stores `count_i` into `slot1_o` and the second stores it into `slot2_o`. Later edges change neither slot until rearm.
- R4: The stored value is the `count_i` value present in the cycle before the slot output changes. The slot output changes on the third rising clock edge after the pin changes (two synchronizer stages, then the capture register).
- R5: `event_o` is a one-cycle pulse, high in the same cycle the slot output updates. With `second_sel_i` = 0 it pulses after the first capture only. With `second_sel_i` = 1 it pulses after the second capture only.
- R6: A one-cycle `rearm_i` pulse resets the slot count to zero, so the next qualifying edge fills slot 1 again. If `rearm_i` and a qualifying edge occur in the same cycle, the rearm wins and that edge is dropped.
- R7: A change of `edge_mode_i` from 0 to a nonzero mode rearms the block. A change between two nonzero modes does not.
- R8: Rearm does not clear the slot contents. Both slots read zero after reset.
- R9: The previous pin level is tracked even while capture is disabled, so enabling capture while the pin is steady high produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W | Counter value to capture |
| edge_mode_i | input | 2 | Edge mode: 0 disabled, 1 rising, 2 falling, 3 both |
| pin_is_input_i | input | 1 | 1 when the pin is configured as an input |
| second_sel_i | input | 1 | 0: event after first capture; 1: event after second capture |
| rearm_i | input | 1 | One-cycle pulse that resets the slot count |
| slot1_o | output | CNT_W | First capture register |
| slot2_o | output | CNT_W | Second capture register |
| event_o | output | 1 | Capture event pulse |

## Verification
On every cycle, the assertions check these properties:
- the slot count never exceeds two;
- a full block, an output-configured pin or a disabled mode leaves both slots untouched;
- a rearm pulse always zeroes the count;
- the event only coincides with a nonzero count.

The bench checks the things a property cannot see, because they depend on a whole edge sequence:
- which counter value lands in which slot;
- the exact cycle of each update;
- that the event appears for the configured capture number and for no other;
- that only the disabled-to-enabled mode change rearms, with no false edge when capture is enabled.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
    end
  endgenerate

  // prev follows regardless of mode: no false edge on enable
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign level_o = sync_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/cap_edge_qual.sv
module cap_edge_qual
  import cap_pkg::*;
(
  input  logic       level_i,
  input  logic       prev_i,
  input  edge_mode_e mode_i,
  input  logic       is_input_i,
  output logic       hit_o
);
  logic rise, fall;
  assign rise = level_i & ~prev_i;
  assign fall = ~level_i & prev_i;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
    if (!is_input_i) hit_o = 1'b0;
  end
endmodule

// File: rtl/cap_slots.sv
module cap_slots
  import cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] count_i,
  input  edge_mode_e       mode_i,
  input  logic             is_input_i,
  input  logic             second_sel_i,
  input  logic             rearm_i,
  output logic [CNT_W-1:0] slot1_o,
  output logic [CNT_W-1:0] slot2_o,
  output logic             event_o
);
  localparam int NUM_W = 2;

  logic [NUM_W-1:0] num_q;
  logic [CNT_W-1:0] slot1_q, slot2_q;
  logic             event_q;
  edge_mode_e       mode_q;
  logic             arm_on_enable, rearm, take;

  assign arm_on_enable = (mode_q == EDGE_OFF) && (mode_i != EDGE_OFF);
  assign rearm         = rearm_i | arm_on_enable;
  assign take          = hit_i && !rearm && (num_q < NUM_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      num_q   <= '0;
      slot1_q <= '0;
      slot2_q <= '0;
      event_q <= 1'b0;
      mode_q  <= EDGE_OFF;
    end else begin
      mode_q  <= mode_i;
      event_q <= 1'b0;
      if (rearm) begin
        num_q <= '0;
      end else if (take) begin
        num_q <= num_q + NUM_W'(1);
        if (num_q == '0) slot1_q <= count_i;
        else             slot2_q <= count_i;
        event_q <= (num_q == NUM_W'(second_sel_i));
      end
    end

  assign slot1_o = slot1_q;
  assign slot2_o = slot2_q;
  assign event_o = event_q;

  a_r3_count_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    num_q <= NUM_W'(2));
  a_r3_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_q == NUM_W'(2) && !rearm_i) |=> ($stable(slot1_q) && $stable(slot2_q)));
  a_r2_output_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_input_i |=> ($stable(slot1_q) && $stable(slot2_q)));
  a_r1_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == EDGE_OFF) |-> !hit_i);
  a_r6_rearm_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (num_q == '0));
  a_r5_event_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |-> (num_q != '0));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             pin_is_input_i,
  input  logic             second_sel_i,
  input  logic             rearm_i,
  output logic [CNT_W-1:0] slot1_o,
  output logic [CNT_W-1:0] slot2_o,
  output logic             event_o
);
  logic       level, prev, hit;
  edge_mode_e mode;
  assign mode = edge_mode_e'(edge_mode_i);

  cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .level_o(level), .prev_o(prev)
  );

  cap_edge_qual u_qual (
    .level_i(level), .prev_i(prev), .mode_i(mode),
    .is_input_i(pin_is_input_i), .hit_o(hit)
  );

  cap_slots #(.CNT_W(CNT_W)) u_slots (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .count_i(count_i),
    .mode_i(mode), .is_input_i(pin_is_input_i), .second_sel_i(second_sel_i),
    .rearm_i(rearm_i), .slot1_o(slot1_o), .slot2_o(slot2_o), .event_o(event_o)
  );
endmodule

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [31:0] cnt = '0;
  logic [1:0]  mode = 2'd0;
  logic        is_in = 1'b0;
  logic        sel = 1'b0;
  logic        rearm = 1'b0;
  logic [31:0] s1, s2;
  logic        ev;

  int checks = 0, fails = 0;
  logic [31:0] exp1 = '0, exp2 = '0;
  int num = 0;
  logic cur_pin = 1'b0;
  logic [31:0] tag = 32'h1000;

  always #2 clk = ~clk;

  edge_capture_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .count_i(cnt),
    .edge_mode_i(mode), .pin_is_input_i(is_in), .second_sel_i(sel),
    .rearm_i(rearm), .slot1_o(s1), .slot2_o(s2), .event_o(ev)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    num = 0;
  endtask

  // drive pin to lvl; model expected outcome; check slots and event pulse
  task automatic edge_to(input logic lvl, input string req);
    logic q, evx;
    @(negedge clk);
    tag = tag + 32'h11;
    cnt = tag; pin = lvl;
    q = 1'b0;
    if (is_in && lvl != cur_pin)
      case (mode)
        2'd1: q = lvl;
        2'd2: q = ~lvl;
        2'd3: q = 1'b1;
        default: q = 1'b0;
      endcase
    cur_pin = lvl;
    evx = 1'b0;
    if (q && num < 2) begin
      if (num == 0) exp1 = tag; else exp2 = tag;
      num++;
      evx = (num == (sel ? 2 : 1));
    end
    cyc(3);
    chk({req, " slot1"}, s1, exp1);
    chk({req, " slot2"}, s2, exp2);
    chk({req, " event"}, {31'd0, ev}, {31'd0, evx});
    cyc(1);
    chk({req, " event drop"}, {31'd0, ev}, 32'd0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(2);
    // R8 reset state
    chk("R8 reset slot1", s1, 32'd0);
    chk("R8 reset slot2", s2, 32'd0);
    chk("R5 reset event", {31'd0, ev}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 sweep of mode x direction x select
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++) begin
          @(negedge clk); mode = 2'd0; pin = 1'b0; cur_pin = 1'b0;
          cyc(4);
          @(negedge clk); mode = 2'(m); is_in = d[0]; sel = s[0];
          do_rearm();
          edge_to(1'b1, "R1 R2 R3 R4 R5 e1");
          edge_to(1'b0, "R1 R2 R3 R4 R5 e2");
          edge_to(1'b1, "R3 R5 e3");
          edge_to(1'b0, "R3 R5 e4");
          edge_to(1'b1, "R3 e5");
          do_rearm();
          edge_to(1'b0, "R6 R8 after rearm e1");
          edge_to(1'b1, "R6 R8 after rearm e2");
        end

    // R6 rearm coinciding with edge: edge dropped
    @(negedge clk); mode = 2'd0; pin = 1'b0; cur_pin = 1'b0; is_in = 1'b1; sel = 1'b0;
    cyc(4);
    @(negedge clk); mode = 2'd3;
    do_rearm();
    @(negedge clk); pin = 1'b1; cur_pin = 1'b1; cnt = 32'hABCD0001;
    @(posedge clk); @(posedge clk); @(negedge clk); rearm = 1'b1;  // edge seen this cycle
    @(negedge clk); rearm = 1'b0;
    cyc(2);
    chk("R6 collide slot1", s1, exp1);
    num = 0;
    edge_to(1'b0, "R6 after collide");

    // R7 mode change between enabled modes keeps count
    @(negedge clk); mode = 2'd1;
    edge_to(1'b1, "R7 second fill");
    @(negedge clk); mode = 2'd2;
    edge_to(1'b0, "R7 full ignore");
    // R7 disabled -> enabled rearms
    @(negedge clk); mode = 2'd0; cyc(1);
    @(negedge clk); mode = 2'd3; num = 0;
    edge_to(1'b1, "R7 rearm on enable");

    // R9 enable with pin steady high: no capture
    @(negedge clk); mode = 2'd0; pin = 1'b1; cur_pin = 1'b1;
    cyc(5);
    @(negedge clk); mode = 2'd1; num = 0;
    cyc(4);
    chk("R9 no false edge slot1", s1, exp1);
    chk("R9 no false edge event", {31'd0, ev}, 32'd0);
    edge_to(1'b0, "R9 fall ignored in rise mode");
    edge_to(1'b1, "R9 real rise");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule